// File: doc/BRIEF.md
# Bus Clock and Opcode-Fetch Strobe Generator

This block turns a free-running reference clock into a bus clock, E, running at one quarter of the reference rate. Each E period is split into two halves. The low half marks the phase in which the core does internal work. The high half marks the phase in which data moves on the bus. The block gives the core one strobe for each half, and it gives the pad ring the E value together with an output enable.

A stop request halts every generated clock, but only at the end of an E period. The counter then waits at the first phase, so when the request goes away E restarts with a full low half and never produces a short high pulse. The E pad can be switched off to reduce emissions, but only in single-chip operation. In expanded operation the pad is always driven.

The block also drives an open-drain fetch indicator. The instruction sequencer raises a start pulse in the last reference cycle of the E period that comes before an opcode fetch. The block then pulls the indicator low for exactly the next E period. At all other times it releases the indicator, and an external pull-up holds the pin high.

Top module: `busclk_gen`

## Requirements
- R1: While running, E is low for two reference cycles and then high for two, so its period is exactly four reference cycles.
- R2: The internal strobe `ph_internal` is high exactly when E is low and running. The access strobe `ph_access` is high exactly when E is high. The two are never high together.
- R3: `stop_req` is only acted on in the fourth phase of a period. A request raised earlier in the period lets the current period finish. From the next cycle on, E and both strobes stay low for as long as `stop_req` stays high.
- R4: When `stop_req` is sampled low while halted, the next cycle is phase 1. E then rises on the third cycle after that sampling edge, and the first high half is a full two cycles.
- R5: `e_pin_oe` is 0 only when `single_chip`=1 and `e_pin_disable`=1. In every other case it is 1. `e_pin` always equals E.
- R6: If `insn_start`=1 in the fourth phase of a running period, `fetch_pull_low` is 1 for all four cycles of the next E period. Otherwise it is 0 in that period.
- R7: If `stop_req` and `insn_start` are both high in the same fourth phase, the halt wins and `fetch_pull_low` stays 0. `insn_start` has no effect while halted.
- R8: While `rst` is high, and after it is released, the block sits in phase 1. E is low, the internal strobe is high and `fetch_pull_low` is 0.
- R9: When `single_chip`=0, `e_pin_disable` has no effect: `e_pin_oe` stays 1 and `e_pin` keeps toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (oscillator) clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to halt all generated clocks |
| single_chip | input | 1 | 1 = single-chip mode, 0 = expanded mode |
| e_pin_disable | input | 1 | Request to turn off the E pad driver |
| insn_start | input | 1 | Sequencer pulse: next E period is an opcode fetch |
| e_int | output | 1 | Internal E clock level |
| ph_internal | output | 1 | Internal-processing phase strobe (E low) |
| ph_access | output | 1 | Data-access phase strobe (E high) |
| e_pin | output | 1 | Value presented to the E pad |
| e_pin_oe | output | 1 | Output enable for the E pad |
| fetch_pull_low | output | 1 | 1 = pull the open-drain fetch pin low, 0 = release |

## Verification
The halt and the fetch strobe are both decided at the same edge, the one that closes an E period. A start pulse and a stop request can therefore arrive in the same fourth phase. The bench drives both in that one cycle and expects the halt to win, with the fetch indicator left released through the whole halted span and through the first period after release. The bench also raises `stop_req` in each of the four phases. It then compares E, both strobes and the indicator, cycle by cycle, against a counter model written from the requirements.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    typedef enum logic {
        CLK_RUN  = 1'b0,
        CLK_HALT = 1'b1
    } clk_state_e;

    typedef struct packed {
        logic e_lvl;
        logic ph_int;
        logic ph_acc;
        logic pad_val;
        logic pad_oe;
    } bus_pins_t;

    // True while the phase index lies in the high (data access) half
    function automatic logic in_access_half(input int unsigned idx,
                                            input int unsigned low_cnt);
        return (idx >= low_cnt);
    endfunction

    // Pad stays enabled unless single-chip operation asks for it off
    function automatic logic pad_enable(input logic single_chip,
                                        input logic disable_req);
        return !(single_chip && disable_req);
    endfunction

endpackage

// File: rtl/busclk_phase_ctr.sv
module busclk_phase_ctr
    import busclk_pkg::*;
#(
    parameter int unsigned DIV = 4,
    localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stop_req,
    output logic [W-1:0] ph_idx,
    output logic         halted,
    output logic         period_end
);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    clk_state_e   state_q;
    logic [W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            state_q <= CLK_RUN;
        end else begin
            unique case (state_q)
                CLK_RUN: begin
                    if (idx_q == LAST) begin
                        idx_q <= '0;
                        if (stop_req) state_q <= CLK_HALT;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                CLK_HALT: begin
                    idx_q <= '0;
                    if (!stop_req) state_q <= CLK_RUN;
                end
                default: state_q <= CLK_RUN;
            endcase
        end
    end

    assign ph_idx     = idx_q;
    assign halted     = (state_q == CLK_HALT);
    assign period_end = (state_q == CLK_RUN) && (idx_q == LAST);
endmodule

// File: rtl/busclk_fetch_strobe.sv
module busclk_fetch_strobe (
    input  logic clk,
    input  logic rst,
    input  logic period_end,
    input  logic stop_req,
    input  logic insn_start,
    output logic pull_low
);
    logic pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_q <= 1'b0;
        end else if (period_end) begin
            // a halt taken at this boundary overrides the fetch
            pull_q <= insn_start && !stop_req;
        end
    end

    assign pull_low = pull_q;
endmodule

// File: rtl/busclk_pin_ctl.sv
module busclk_pin_ctl
    import busclk_pkg::*;
#(
    parameter int unsigned DIV     = 4,
    parameter int unsigned LOW_CNT = 2,
    localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic [W-1:0] ph_idx,
    input  logic         halted,
    input  logic         single_chip,
    input  logic         e_pin_disable,
    output bus_pins_t    pins
);
    logic hi_half;

    always_comb begin
        hi_half      = in_access_half(int'(ph_idx), LOW_CNT);
        pins.e_lvl   = !halted && hi_half;
        pins.ph_int  = !halted && !hi_half;
        pins.ph_acc  = !halted && hi_half;
        pins.pad_val = pins.e_lvl;
        pins.pad_oe  = pad_enable(single_chip, e_pin_disable);
    end
endmodule

// File: rtl/busclk_gen.sv
module busclk_gen
    import busclk_pkg::*;
#(
    parameter int unsigned DIV     = 4,
    parameter int unsigned LOW_CNT = DIV / 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic single_chip,
    input  logic e_pin_disable,
    input  logic insn_start,
    output logic e_int,
    output logic ph_internal,
    output logic ph_access,
    output logic e_pin,
    output logic e_pin_oe,
    output logic fetch_pull_low
);
    localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [W-1:0] ph_idx;
    logic         halted;
    logic         period_end;
    bus_pins_t    pins;

    busclk_phase_ctr #(.DIV(DIV)) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .stop_req   (stop_req),
        .ph_idx     (ph_idx),
        .halted     (halted),
        .period_end (period_end)
    );

    busclk_fetch_strobe u_fetch (
        .clk        (clk),
        .rst        (rst),
        .period_end (period_end),
        .stop_req   (stop_req),
        .insn_start (insn_start),
        .pull_low   (fetch_pull_low)
    );

    busclk_pin_ctl #(.DIV(DIV), .LOW_CNT(LOW_CNT)) u_pins (
        .ph_idx        (ph_idx),
        .halted        (halted),
        .single_chip   (single_chip),
        .e_pin_disable (e_pin_disable),
        .pins          (pins)
    );

    assign e_int       = pins.e_lvl;
    assign ph_internal = pins.ph_int;
    assign ph_access   = pins.ph_acc;
    assign e_pin       = pins.pad_val;
    assign e_pin_oe    = pins.pad_oe;
endmodule

// File: rtl/busclk_gen_chk.sv
module busclk_gen_chk (
    input logic clk,
    input logic rst,
    input logic stop_req,
    input logic single_chip,
    input logic insn_start,
    input logic e_int,
    input logic ph_internal,
    input logic ph_access,
    input logic e_pin,
    input logic e_pin_oe,
    input logic fetch_pull_low,
    input logic halted
);
    AST_HIGH_HALF_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(e_int) |=> e_int);                                          // R1

    AST_LOW_HALF_TWO: assert property (@(posedge clk) disable iff (rst)
        ($fell(e_int) && !halted) |=> !e_int);                            // R1

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ph_internal, ph_access}));                              // R2

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!e_int && !ph_internal && !ph_access));               // R3

    AST_HALT_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(ph_access));                              // R3

    AST_RESUME_PH1: assert property (@(posedge clk) disable iff (rst)
        $fell(halted) |-> (ph_internal && !e_int));                       // R4

    AST_EXPANDED_OE: assert property (@(posedge clk) disable iff (rst)
        !single_chip |-> (e_pin_oe && (e_pin == e_int)));                 // R9

    AST_FETCH_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(fetch_pull_low) |-> $fell(e_int));                       // R6

    AST_FETCH_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted |-> !fetch_pull_low);                                      // R7
endmodule

bind busclk_gen busclk_gen_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .stop_req       (stop_req),
    .single_chip    (single_chip),
    .insn_start     (insn_start),
    .e_int          (e_int),
    .ph_internal    (ph_internal),
    .ph_access      (ph_access),
    .e_pin          (e_pin),
    .e_pin_oe       (e_pin_oe),
    .fetch_pull_low (fetch_pull_low),
    .halted         (halted)
);

// File: tb/busclk_gen_bench.sv
`timescale 1ns/1ps
module busclk_gen_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 1'b0;
    logic single_chip = 1'b0;
    logic e_pin_disable = 1'b0;
    logic insn_start = 1'b0;
    logic e_int, ph_internal, ph_access, e_pin, e_pin_oe, fetch_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model, written from the requirements
    int  m_ph   = 0;
    bit  m_halt = 1'b0;
    bit  m_ftch = 1'b0;

    always #5 clk = ~clk;

    busclk_gen u_busclk_gen (
        .clk            (clk),
        .rst            (rst),
        .stop_req       (stop_req),
        .single_chip    (single_chip),
        .e_pin_disable  (e_pin_disable),
        .insn_start     (insn_start),
        .e_int          (e_int),
        .ph_internal    (ph_internal),
        .ph_access      (ph_access),
        .e_pin          (e_pin),
        .e_pin_oe       (e_pin_oe),
        .fetch_pull_low (fetch_pull_low)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_halt = 1'b0; m_ftch = 1'b0;
        end else if (m_halt) begin
            m_ph = 0;
            if (!stop_req) m_halt = 1'b0;
        end else if (m_ph == 3) begin
            m_ftch = insn_start && !stop_req;
            m_halt = stop_req;
            m_ph = 0;
        end else begin
            m_ph = m_ph + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit ee;
        ee = !m_halt && (m_ph >= 2);
        check(e_int == ee, "R1 e_int", e_int, ee);
        check(ph_internal == (!m_halt && m_ph < 2), "R2 ph_internal", ph_internal, !m_halt && m_ph < 2);
        check(ph_access == ee, "R2 ph_access", ph_access, ee);
        check(e_pin == ee, "R5 e_pin", e_pin, ee);
        check(e_pin_oe == !(single_chip && e_pin_disable), "R5_R9 e_pin_oe",
              e_pin_oe, !(single_chip && e_pin_disable));
        check(fetch_pull_low == m_ftch, "R6 fetch_pull_low", fetch_pull_low, m_ftch);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(e_int == 1'b0 && ph_internal == 1'b1, "R8 reset phase", e_int, 0);
        check(fetch_pull_low == 1'b0, "R8 fetch released", fetch_pull_low, 0);
        rst = 1'b0;
        tick();
        check(ph_internal == 1'b1, "R8 phase1 after release", ph_internal, 1);

        // R1/R2 free run, R5/R9 all mode and disable combinations
        for (int m = 0; m < 4; m++) begin
            single_chip   = m[1];
            e_pin_disable = m[0];
            for (int i = 0; i < 16; i++) tick();
        end
        single_chip = 1'b0; e_pin_disable = 1'b0;

        // R6: start pulse held in each of the four phases
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 8; i++) begin
                insn_start = (m_ph == p);
                tick();
            end
            insn_start = 1'b0;
            for (int i = 0; i < 8; i++) tick();
        end

        // R3/R4: stop raised in each phase, held, then released
        for (int p = 0; p < 4; p++) begin
            while (m_ph != p) tick();
            stop_req = 1'b1;
            for (int i = 0; i < 9; i++) tick();
            check(m_halt && e_int == 1'b0, "R3 halted low", e_int, 0);
            insn_start = 1'b1;   // R7: ignored while halted
            tick();
            insn_start = 1'b0;
            stop_req = 1'b0;
            tick();
            check(ph_internal == 1'b1 && e_int == 1'b0, "R4 resume phase1", e_int, 0);
            tick();
            check(e_int == 1'b0, "R4 second low cycle", e_int, 0);
            tick();
            check(e_int == 1'b1, "R4 first high", e_int, 1);
            tick();
            check(e_int == 1'b1, "R4 full high half", e_int, 1);
            check(fetch_pull_low == 1'b0, "R7 no fetch after halt", fetch_pull_low, 0);
        end

        // R7: stop and start pulse in the same fourth phase
        while (m_ph != 3) tick();
        stop_req = 1'b1; insn_start = 1'b1;
        tick();
        insn_start = 1'b0;
        check(fetch_pull_low == 1'b0, "R7 halt wins", fetch_pull_low, 0);
        for (int i = 0; i < 4; i++) tick();
        stop_req = 1'b0;
        for (int i = 0; i < 12; i++) tick();

        // R9: disable bit toggled in expanded mode
        single_chip = 1'b0;
        for (int i = 0; i < 8; i++) begin
            e_pin_disable = i[0];
            tick();
            check(e_pin_oe == 1'b1, "R9 expanded oe", e_pin_oe, 1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule